// File: doc/BRIEF.md
# Processor Power-Rail and PMIC Sequencer

This block powers a processor up and down. The processor is fed by a switched-capacitor converter and a PMIC. An on command raises the 3.3 V and 5 V auxiliary rails and the converter enable together. The block then waits for the converter's power-good, lets the supply settle, and starts the PMIC by holding an active-low key-press line until the PMIC reports POWER_GOOD. An off command asks the PMIC for a graceful shutdown, holding the key-press and reset-in lines low together. The block then switches the converter off, waits for everything to drain, and drops the auxiliary rails.

All timing counts a one-millisecond tick. Each wait is a poll with a timeout, and a fixed settle delay follows each supply step. A timeout raises `err`. A failure anywhere in power-up sends the block through the complete power-down sequence, so the rails never stay half on. Commands are taken only while the block is idle. `done` marks the end of every sequence.

Top module: `pmic_rail_seq`

## Requirements
- R1: While reset is asserted, all rail and converter enables are 0, `kpd_drv_n` and `resin_n` are 1, and `busy`, `done` and `err` are 0.
- R2: An accepted on command raises `en_3v3`, `en_5v`, `conv_en` and `busy` in the same clock. The block then waits for `conv_pg`, then waits SETTLE_MS ticks, then decides on the PMIC trigger.
- R3: `conv_pg` is sampled on entry to the wait and again after every PG_POLL_MS ticks. The wait gives up after PG_TIMEOUT_MS ticks. A timeout sets `err`, but the settle delay that follows still runs.
- R4: The PMIC power-on trigger holds `kpd_drv_n` at 0 until `pwr_good` is 1. It samples every PMIC_POLL_MS ticks and gives up after PMIC_TIMEOUT_MS ticks. `kpd_drv_n` then returns to 1.
- R5: If `pwr_good` already matches the requested state, the PMIC trigger is skipped: `kpd_drv_n` stays 1 and no error is raised.
- R6: If `kpd_sense` reads 0 when a PMIC trigger is due, the trigger is skipped and `err` is set.
- R7: If power-up fails (converter timeout, missing key-press pull-up, or PMIC timeout), the full power-down sequence runs and the block finishes with all enables at 0 and `err` = 1.
- R8: Power-down first checks `pwr_good`. If it is 1, the block drives `kpd_drv_n` and `resin_n` to 0 until `pwr_good` is 0 (PMIC timeout rules apply), releases both lines, and waits SETTLE_MS ticks.
- R9: The converter is switched off only if it is enabled. The block then waits for `conv_pg` to drop (converter timing), waits up to DRAIN_TIMEOUT_MS ticks for `pwr_good` to drop, and waits SETTLE_MS ticks. Only after that do `en_3v3` and `en_5v` fall.
- R10: Commands arriving while `busy` is 1 are ignored. When both commands arrive in the same idle clock, the off command wins.
- R11: `done` is 1 for exactly one clock at the end of each sequence, in the same clock that `busy` falls.
- R12: `err` keeps its value until the next accepted command clears it.
- R13: `kpd_drv_n` goes low only while `busy` is 1. `resin_n` goes low only while `kpd_drv_n` is also low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-clock pulse every millisecond |
| cmd_on | input | 1 | Power-up request |
| cmd_off | input | 1 | Power-down request |
| conv_pg | input | 1 | Converter output good |
| pwr_good | input | 1 | PMIC/processor POWER_GOOD |
| kpd_sense | input | 1 | Readback of the key-press line (1 = pulled high) |
| en_3v3 | output | 1 | 3.3 V rail enable |
| en_5v | output | 1 | 5 V rail enable |
| conv_en | output | 1 | Converter enable |
| kpd_drv_n | output | 1 | Key-press drive, active low |
| resin_n | output | 1 | PMIC reset-in drive, active low |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-clock end-of-sequence pulse |
| err | output | 1 | Some step of the last sequence failed |

## Verification
The bench runs the following patterns against a small supply model:
- **Cooperative supply:** exercises the plain up and down orderings.
- **Silent converter:** separates a flagged timeout that still settles from one that aborts.
- **Unresponsive PMIC:** distinguishes the power-on trigger timeout from the power-down trigger timeout; during power-down it also shows whether the drain wait catches the late `pwr_good` drop.
- **Missing key-press pull-up:** isolates the skipped-trigger error path.
- **`pwr_good` already high at power-up:** checks that the trigger is skipped without an error.

A behavioural reference model is compared with every output on every clock. It also separates ignored mid-sequence commands and simultaneous on/off requests from accepted ones.

// File: rtl/pmic_rail_seq.sv
module pmic_rail_seq #(
  parameter int PG_POLL_MS       = 6,
  parameter int PG_TIMEOUT_MS    = 100,
  parameter int SETTLE_MS        = 150,
  parameter int PMIC_POLL_MS     = 1,
  parameter int PMIC_TIMEOUT_MS  = 350,
  parameter int DRAIN_TIMEOUT_MS = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic cmd_on,
  input  logic cmd_off,
  input  logic conv_pg,
  input  logic pwr_good,
  input  logic kpd_sense,
  output logic en_3v3,
  output logic en_5v,
  output logic conv_en,
  output logic kpd_drv_n,
  output logic resin_n,
  output logic busy,
  output logic done,
  output logic err
);
  localparam int M1    = (PG_TIMEOUT_MS > PMIC_TIMEOUT_MS) ? PG_TIMEOUT_MS : PMIC_TIMEOUT_MS;
  localparam int M2    = (M1 > DRAIN_TIMEOUT_MS) ? M1 : DRAIN_TIMEOUT_MS;
  localparam int MAXMS = (M2 > SETTLE_MS) ? M2 : SETTLE_MS;
  localparam int CW    = $clog2(MAXMS + 2);

  typedef enum logic [3:0] {
    S_IDLE, S_CPG_ON, S_ON_SETTLE, S_PMIC_ON, S_OFF_START, S_PMIC_OFF,
    S_OFF_SETTLE, S_CONV_CHK, S_CPG_OFF, S_PG_DROP, S_DRAIN_SETTLE
  } state_t;

  state_t st;
  logic [CW-1:0] ms, pc, w_poll, w_to;
  logic due, is_wait, w_cond, w_fin, d_fin;

  wire is_dly = (st == S_ON_SETTLE) || (st == S_OFF_SETTLE) || (st == S_DRAIN_SETTLE);

  always_comb begin
    is_wait = 1'b1;
    w_cond  = 1'b0;
    w_poll  = CW'(PMIC_POLL_MS);
    w_to    = CW'(PMIC_TIMEOUT_MS);
    case (st)
      S_CPG_ON:   begin w_cond = conv_pg;   w_poll = CW'(PG_POLL_MS); w_to = CW'(PG_TIMEOUT_MS); end
      S_CPG_OFF:  begin w_cond = !conv_pg;  w_poll = CW'(PG_POLL_MS); w_to = CW'(PG_TIMEOUT_MS); end
      S_PMIC_ON:  w_cond = pwr_good;
      S_PMIC_OFF: w_cond = !pwr_good;
      S_PG_DROP:  begin w_cond = !pwr_good; w_to = CW'(DRAIN_TIMEOUT_MS); end
      default:    is_wait = 1'b0;
    endcase
  end

  assign w_fin = is_wait && due && (w_cond || ms >= w_to);
  assign d_fin = is_dly && tick_ms && (ms + 1'b1 == CW'(SETTLE_MS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms <= '0; pc <= '0; due <= 1'b1;
    end else if (!(is_wait || is_dly) || w_fin || d_fin) begin
      ms <= '0; pc <= '0; due <= 1'b1;
    end else if (is_wait) begin
      if (due) due <= 1'b0;
      else if (tick_ms) begin
        ms <= ms + 1'b1;
        if (pc + 1'b1 == w_poll || ms + 1'b1 >= w_to) begin
          due <= 1'b1; pc <= '0;
        end else pc <= pc + 1'b1;
      end
    end else if (tick_ms) ms <= ms + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; en_3v3 <= 1'b0; en_5v <= 1'b0; conv_en <= 1'b0;
      kpd_drv_n <= 1'b1; resin_n <= 1'b1; busy <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE:
          if (cmd_off) begin
            busy <= 1'b1; err <= 1'b0; st <= S_OFF_START;
          end else if (cmd_on) begin
            busy <= 1'b1; err <= 1'b0;
            en_3v3 <= 1'b1; en_5v <= 1'b1; conv_en <= 1'b1;
            st <= S_CPG_ON;
          end
        S_CPG_ON:
          if (w_fin) begin
            if (!w_cond) err <= 1'b1;
            st <= S_ON_SETTLE;
          end
        S_ON_SETTLE:
          if (d_fin) begin
            if (err) st <= S_OFF_START;
            else if (pwr_good) begin busy <= 1'b0; done <= 1'b1; st <= S_IDLE; end
            else if (!kpd_sense) begin err <= 1'b1; st <= S_OFF_START; end
            else begin kpd_drv_n <= 1'b0; st <= S_PMIC_ON; end
          end
        S_PMIC_ON:
          if (w_fin) begin
            kpd_drv_n <= 1'b1;
            if (w_cond) begin busy <= 1'b0; done <= 1'b1; st <= S_IDLE; end
            else begin err <= 1'b1; st <= S_OFF_START; end
          end
        S_OFF_START:
          if (pwr_good && kpd_sense) begin
            kpd_drv_n <= 1'b0; resin_n <= 1'b0; st <= S_PMIC_OFF;
          end else if (pwr_good) begin
            err <= 1'b1; st <= S_OFF_SETTLE;
          end else st <= S_CONV_CHK;
        S_PMIC_OFF:
          if (w_fin) begin
            kpd_drv_n <= 1'b1; resin_n <= 1'b1;
            if (!w_cond) err <= 1'b1;
            st <= S_OFF_SETTLE;
          end
        S_OFF_SETTLE:
          if (d_fin) st <= S_CONV_CHK;
        S_CONV_CHK:
          if (conv_en) begin
            conv_en <= 1'b0; st <= S_CPG_OFF;
          end else begin
            en_3v3 <= 1'b0; en_5v <= 1'b0; busy <= 1'b0; done <= 1'b1; st <= S_IDLE;
          end
        S_CPG_OFF:
          if (w_fin) begin
            if (!w_cond) err <= 1'b1;
            st <= S_PG_DROP;
          end
        S_PG_DROP:
          if (w_fin) begin
            if (!w_cond) err <= 1'b1;
            st <= S_DRAIN_SETTLE;
          end
        S_DRAIN_SETTLE:
          if (d_fin) begin
            en_3v3 <= 1'b0; en_5v <= 1'b0; busy <= 1'b0; done <= 1'b1; st <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r13_kpd_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !kpd_drv_n |-> busy);
  a_r13_resin_with_kpd: assert property (@(posedge clk) disable iff (!rst_n)
    !resin_n |-> !kpd_drv_n);
  a_r11_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r10_start_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_on || cmd_off));
  a_r12_err_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $rose(busy));
  a_r9_conv_under_rails: assert property (@(posedge clk) disable iff (!rst_n)
    conv_en |-> (en_3v3 && en_5v));
endmodule

// File: tb/sim_pmic_rail_seq.sv
module sim_pmic_rail_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PGP = 2, PGT = 6, STL = 3, PMP = 1, PMT = 5, DRT = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick_ms = 1'b0, cmd_on = 1'b0, cmd_off = 1'b0;
  logic conv_pg = 1'b0, pwr_good = 1'b0, kpd_sense;
  logic en_3v3, en_5v, conv_en, kpd_drv_n, resin_n, busy, done, err;
  logic kpd_pull = 1'b1, conv_ok = 1'b1, on_resp = 1'b1, off_resp = 1'b1, force_pg = 1'b0;
  logic cmp_on = 1'b0;
  int n_chk = 0, n_err = 0, cyc = 0, cc = 0, kc = 0, offc = 20, kpd_low_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign kpd_sense = kpd_pull & kpd_drv_n;

  pmic_rail_seq #(.PG_POLL_MS(PGP), .PG_TIMEOUT_MS(PGT), .SETTLE_MS(STL),
    .PMIC_POLL_MS(PMP), .PMIC_TIMEOUT_MS(PMT), .DRAIN_TIMEOUT_MS(DRT)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .cmd_on(cmd_on), .cmd_off(cmd_off),
    .conv_pg(conv_pg), .pwr_good(pwr_good), .kpd_sense(kpd_sense),
    .en_3v3(en_3v3), .en_5v(en_5v), .conv_en(conv_en), .kpd_drv_n(kpd_drv_n),
    .resin_n(resin_n), .busy(busy), .done(done), .err(err));

  task automatic chk(input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", what, act, exp, $time);
    end
  endtask

  // supply model
  always @(negedge clk) begin
    cyc++;
    tick_ms = (cyc % 3 == 0);
    cc = conv_en ? (cc < 50 ? cc + 1 : cc) : 0;
    conv_pg = conv_ok && (cc >= 4);
    kc = !kpd_drv_n ? kc + 1 : 0;
    offc = conv_en ? 0 : (offc < 20 ? offc + 1 : offc);
    if (on_resp && !kpd_drv_n && resin_n && kc >= 5) pwr_good = 1'b1;
    if (off_resp && !kpd_drv_n && !resin_n && kc >= 5) pwr_good = 1'b0;
    if (offc == 10) pwr_good = 1'b0;
    if (force_pg) begin pwr_good = 1'b1; force_pg = 1'b0; end
    if (!kpd_drv_n) kpd_low_n++;
  end

  // reference model
  logic e3 = 0, e5 = 0, ec = 0, ek = 1, er = 1, eb = 0, ed = 0, ee = 0;

  function automatic bit cond(input int sel);
    case (sel)
      0: return conv_pg;
      1: return !conv_pg;
      2: return pwr_good;
      default: return !pwr_good;
    endcase
  endfunction

  task automatic m_wait(input int sel, input int poll, input int to, output bit ok);
    int t = 0, p = 0;
    bit due = 1;
    forever begin
      @(posedge clk);
      if (due) begin
        if (cond(sel)) begin ok = 1; return; end
        if (t >= to) begin ok = 0; return; end
        due = 0;
      end else if (tick_ms) begin
        t++; p++;
        if (p == poll || t >= to) begin due = 1; p = 0; end
      end
    end
  endtask

  task automatic m_dly(input int n);
    int c = 0;
    forever begin
      @(posedge clk);
      if (tick_ms) begin c++; if (c == n) return; end
    end
  endtask

  task automatic m_off();
    bit ok;
    @(posedge clk);
    if (pwr_good) begin
      if (kpd_pull) begin
        ek = 0; er = 0;
        m_wait(3, PMP, PMT, ok);
        ek = 1; er = 1;
        if (!ok) ee = 1;
      end else ee = 1;
      m_dly(STL);
    end
    @(posedge clk);
    if (ec) begin
      ec = 0;
      m_wait(1, PGP, PGT, ok); if (!ok) ee = 1;
      m_wait(3, PMP, DRT, ok); if (!ok) ee = 1;
      m_dly(STL);
    end
    e3 = 0; e5 = 0; eb = 0; ed = 1;
  endtask

  task automatic m_on();
    bit ok;
    m_wait(0, PGP, PGT, ok);
    if (!ok) ee = 1;
    m_dly(STL);
    if (ee) m_off();
    else if (pwr_good) begin eb = 0; ed = 1; end
    else if (!kpd_pull) begin ee = 1; m_off(); end
    else begin
      ek = 0;
      m_wait(2, PMP, PMT, ok);
      ek = 1;
      if (ok) begin eb = 0; ed = 1; end
      else begin ee = 1; m_off(); end
    end
  endtask

  always begin
    @(posedge clk);
    ed = 0;
    if (!rst_n) begin
      e3 = 0; e5 = 0; ec = 0; ek = 1; er = 1; eb = 0; ee = 0;
    end else if (cmd_off) begin
      eb = 1; ee = 0; m_off();
    end else if (cmd_on) begin
      e3 = 1; e5 = 1; ec = 1; eb = 1; ee = 0; m_on();
    end
  end

  always @(negedge clk) if (cmp_on) begin
    chk("R2 en_3v3", en_3v3, e3);
    chk("R2 en_5v", en_5v, e5);
    chk("R9 conv_en", conv_en, ec);
    chk("R4 kpd_drv_n", kpd_drv_n, ek);
    chk("R8 resin_n", resin_n, er);
    chk("R10 busy", busy, eb);
    chk("R11 done", done, ed);
    chk("R12 err", err, ee);
    chk("R13 resin without kpd", !resin_n && kpd_drv_n, 1'b0);
  end

  always @(negedge clk) if (cyc > 100000) begin
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      if (done) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic issue(input logic on, input logic off);
    @(negedge clk);
    cmd_on = on; cmd_off = off;
    @(negedge clk);
    cmd_on = 1'b0; cmd_off = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 en_3v3", en_3v3, 1'b0);
    chk("R1 conv_en", conv_en, 1'b0);
    chk("R1 kpd_drv_n", kpd_drv_n, 1'b1);
    chk("R1 resin_n", resin_n, 1'b1);
    chk("R1 busy", busy, 1'b0);
    chk("R1 err", err, 1'b0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    repeat (3) @(negedge clk);

    // normal power-up with an off command ignored mid-sequence
    issue(1'b1, 1'b0);
    repeat (4) @(negedge clk);
    cmd_off = 1'b1; @(negedge clk); cmd_off = 1'b0;
    wait_done();
    chk("R2 rails up after on", en_3v3 && conv_en, 1'b1);
    chk("R10 mid-sequence off ignored", pwr_good, 1'b1);
    chk("R4 pmic up, no error", err, 1'b0);

    // graceful power-down
    issue(1'b0, 1'b1);
    wait_done();
    chk("R8 pmic off", pwr_good, 1'b0);
    chk("R9 rails down", en_3v3 | en_5v | conv_en, 1'b0);

    // off while already off
    issue(1'b0, 1'b1);
    wait_done();
    chk("R9 idle off no error", err, 1'b0);

    // converter never good
    conv_ok = 1'b0;
    issue(1'b1, 1'b0);
    wait_done();
    conv_ok = 1'b1;
    chk("R3 converter timeout err", err, 1'b1);
    chk("R7 rails down after failure", en_3v3 | conv_en, 1'b0);

    // PMIC ignores power-on trigger
    on_resp = 1'b0;
    issue(1'b1, 1'b0);
    wait_done();
    on_resp = 1'b1;
    chk("R4 pmic timeout err", err, 1'b1);
    chk("R7 rails down after pmic timeout", en_5v | conv_en, 1'b0);

    // key-press not pulled up
    kpd_pull = 1'b0;
    kpd_low_n = 0;
    issue(1'b1, 1'b0);
    wait_done();
    kpd_pull = 1'b1;
    chk("R6 missing pull-up err", err, 1'b1);
    chk("R6 no key-press drive", kpd_low_n == 0, 1'b1);

    // POWER_GOOD already high: trigger skipped
    @(negedge clk); force_pg = 1'b1;
    @(negedge clk);
    kpd_low_n = 0;
    issue(1'b1, 1'b0);
    wait_done();
    chk("R5 skip no key-press", kpd_low_n == 0, 1'b1);
    chk("R5 skip no error", err, 1'b0);

    // PMIC ignores power-off trigger; drain catches the drop
    off_resp = 1'b0;
    issue(1'b0, 1'b1);
    wait_done();
    off_resp = 1'b1;
    chk("R8 pmic off timeout err", err, 1'b1);
    chk("R9 drained", pwr_good | en_3v3, 1'b0);
    chk("R12 err held while idle", err, 1'b1);

    // both commands at once: off wins, err cleared
    issue(1'b1, 1'b1);
    wait_done();
    chk("R10 off wins", en_3v3 | conv_en, 1'b0);
    chk("R12 err cleared by command", err, 1'b0);

    issue(1'b1, 1'b0);
    wait_done();
    chk("R2 final power-up", en_3v3 && pwr_good, 1'b1);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule